// File: doc/BRIEF.md
# Colour channel sampling sequencer

This block decides which of three colour inputs (red, green, blue) the analog front end samples in each channel slot of a pixel period. Configuration pins choose the mode. In three-channel mode the block cycles through all three colours in a forward or reverse order. In two-channel mode it alternates between a chosen pair. In one-channel mode it stays on one colour. The block drives a one-hot channel select for the analog multiplexer. It also drives a binary channel tag that travels with the converted data downstream.

All registers run on the sample clock `clk`. The reference-sample strobe `ref_strobe` marks a slot boundary: the sequence steps on a clock edge that sees it high. In three-channel mode a rising edge of the data-sample strobe `data_strobe` restarts the sequence at its first colour. Power-down freezes every register, including the strobe edge history, so no state is lost.

The controller has three states, named after the channel they select: CH_R, CH_G and CH_B. It has four kinds of transition. *restart* jumps to the first colour on a data-strobe rise in three-channel mode. *advance* rotates one colour forward (CH_R→CH_G→CH_B→CH_R) or backward (CH_B→CH_G→CH_R→CH_B) on a step. *swap* alternates within the pair on a step. *pin* forces the single or fallback colour on every active clock.

Top module: `chan_seq_top`

## Requirements
- R1: While `rst_n` is low, `chan_sel` is 3'b001 and `chan_tag` is 0 (red).
- R2: `chan_sel` is always one-hot and equals 1 << `chan_tag`. The codes are red=0/bit0, green=1/bit1 and blue=2/bit2.
- R3: With `tri_mode`=1, each active clock with `ref_strobe`=1 and no data-strobe rise moves the channel one step. The order is R→G→B→R when `order_rgb`=1 and B→G→R→B when `order_rgb`=0. The outputs change on that same clock edge and are valid in the following cycle.
- R4: With `tri_mode`=1, a rising edge of `data_strobe` (high now, low at the previous active clock) sets the channel to red when `order_rgb`=1 and to blue when it is 0. This takes priority over a step. A strobe held high restarts only once.
- R5: With `tri_mode`=0 and exactly one bit of `chan_en` set (bit0 red, bit1 green, bit2 blue), the channel stays on that colour whatever the strobes do.
- R6: In one-channel mode `order_rgb` has no effect on the selected channel.
- R7: With `tri_mode`=0 and exactly two `chan_en` bits set, each step alternates between the two colours. From a channel outside the pair, or from the second colour of the pair, a step goes to the first colour. The first colour is the lower-coded one when `order_rgb`=1 and the higher-coded one when it is 0. No step means no change.
- R8: With `tri_mode`=0 and zero or three `chan_en` bits set, the channel is red.
- R9: While `pwr_down`=1, neither the outputs nor the strobe edge history change. After release, the block resumes from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_strobe | input | 1 | Reference-sample strobe; a high level marks a step |
| data_strobe | input | 1 | Data-sample strobe; its rise restarts the three-channel sequence |
| tri_mode | input | 1 | 1 = three-channel mode |
| pwr_down | input | 1 | 1 = freeze all state |
| order_rgb | input | 1 | 1 = red-first ordering, 0 = blue-first ordering |
| chan_en | input | 3 | Channel enables: bit0 red, bit1 green, bit2 blue |
| chan_sel | output | 3 | One-hot registered channel select |
| chan_tag | output | 2 | Registered channel code (0 red, 1 green, 2 blue) |

## Verification
The bench builds the block with its only configuration: three channels and a two-bit tag. With this configuration the full configuration space is small. It sweeps all 32 combinations of `tri_mode`, `order_rgb` and `chan_en`, with pseudo-random strobe and power-down patterns, so every mode is entered from every colour. The state it carries from one combination into the next covers the pair-entry case from a colour outside the pair. The expected channel is computed each cycle as an index modulo three. That index is checked against both outputs.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
    localparam int NUM_CH = 3;
    localparam int TAG_W  = $clog2(NUM_CH);

    typedef enum logic [TAG_W-1:0] {
        CH_R = 2'd0,
        CH_G = 2'd1,
        CH_B = 2'd2
    } ch_e;

    typedef enum logic [1:0] {
        MD_TRI,
        MD_PAIR,
        MD_SINGLE,
        MD_FALLBACK
    } mode_e;

    typedef struct packed {
        mode_e mode;
        ch_e   first;
        ch_e   second;
    } plan_t;
endpackage

// File: rtl/chan_mode_dec.sv
module chan_mode_dec
    import chan_seq_pkg::*;
(
    input  logic              tri_mode,
    input  logic              order_rgb,
    input  logic [NUM_CH-1:0] chan_en,
    output plan_t             plan
);
    localparam int CNT_W = $clog2(NUM_CH + 1);

    logic [CNT_W-1:0] n_set;
    ch_e              lo_ch;
    ch_e              hi_ch;
    logic             seen;

    always_comb begin
        n_set = '0;
        lo_ch = CH_R;
        hi_ch = CH_R;
        seen  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan_en[i]) begin
                n_set = n_set + 1'b1;
                hi_ch = ch_e'(TAG_W'(i));
                if (!seen) begin
                    lo_ch = ch_e'(TAG_W'(i));
                    seen  = 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (tri_mode) begin
            plan.mode   = MD_TRI;
            plan.first  = order_rgb ? CH_R : CH_B;
            plan.second = CH_G;
        end else if (n_set == CNT_W'(1)) begin
            plan.mode   = MD_SINGLE;
            plan.first  = lo_ch;
            plan.second = lo_ch;
        end else if (n_set == CNT_W'(2)) begin
            plan.mode   = MD_PAIR;
            plan.first  = order_rgb ? lo_ch : hi_ch;
            plan.second = order_rgb ? hi_ch : lo_ch;
        end else begin
            plan.mode   = MD_FALLBACK;
            plan.first  = CH_R;
            plan.second = CH_R;
        end
    end
endmodule

// File: rtl/chan_strobe_edge.sv
module chan_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic strobe,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else if (!hold)
            prev_q <= strobe;
    end

    assign rise = strobe & ~prev_q;

    AST_HOLD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(prev_q)); // R9
endmodule

// File: rtl/chan_seq_fsm.sv
module chan_seq_fsm
    import chan_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              step,
    input  logic              rise,
    input  plan_t             plan,
    output logic [NUM_CH-1:0] chan_sel,
    output logic [TAG_W-1:0]  chan_tag
);
    ch_e state_q;
    ch_e state_d;

    function automatic ch_e rotate(input ch_e cur, input logic fwd);
        ch_e nx;
        unique case (cur)
            CH_R:    nx = fwd ? CH_G : CH_B;
            CH_G:    nx = fwd ? CH_B : CH_R;
            CH_B:    nx = fwd ? CH_R : CH_G;
            default: nx = CH_R;
        endcase
        return nx;
    endfunction

    always_comb begin
        state_d = state_q;
        if (!hold) begin
            unique case (plan.mode)
                MD_TRI: begin
                    if (rise)
                        state_d = plan.first;
                    else if (step)
                        state_d = rotate(state_q, plan.first == CH_R);
                end
                MD_PAIR: begin
                    if (step)
                        state_d = (state_q == plan.first) ? plan.second : plan.first;
                end
                MD_SINGLE, MD_FALLBACK: begin
                    state_d = plan.first;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_R;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_sel <= NUM_CH'(1);
            chan_tag <= TAG_W'(CH_R);
        end else begin
            chan_sel <= NUM_CH'(1) << state_d;
            chan_tag <= state_d;
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_sel) == 1); // R2
    AST_SEL_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        chan_sel == (NUM_CH'(1) << chan_tag)); // R2
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(chan_sel) && $stable(chan_tag))); // R9
endmodule

// File: rtl/chan_seq_top.sv
module chan_seq_top
    import chan_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_strobe,
    input  logic              data_strobe,
    input  logic              tri_mode,
    input  logic              pwr_down,
    input  logic              order_rgb,
    input  logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] chan_sel,
    output logic [TAG_W-1:0]  chan_tag
);
    plan_t plan;
    logic  ds_rise;

    chan_mode_dec u_dec (
        .tri_mode (tri_mode),
        .order_rgb(order_rgb),
        .chan_en  (chan_en),
        .plan     (plan)
    );

    chan_strobe_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (pwr_down),
        .strobe(data_strobe),
        .rise  (ds_rise)
    );

    chan_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (pwr_down),
        .step    (ref_strobe),
        .rise    (ds_rise),
        .plan    (plan),
        .chan_sel(chan_sel),
        .chan_tag(chan_tag)
    );

    AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_mode && ds_rise && !pwr_down) |=>
            (chan_tag == ($past(order_rgb) ? TAG_W'(CH_R) : TAG_W'(CH_B)))); // R4
    AST_SINGLE_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        (plan.mode == MD_SINGLE && !pwr_down) |=> (chan_tag == $past(plan.first))); // R5
    AST_FALLBACK_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (plan.mode == MD_FALLBACK && !pwr_down) |=> (chan_tag == TAG_W'(CH_R))); // R8
    AST_PAIR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (plan.mode == MD_PAIR && ref_strobe && !pwr_down && chan_tag == plan.first) |=>
            (chan_tag == $past(plan.second))); // R7
endmodule

// File: tb/chan_seq_top_tb.sv
module chan_seq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_strobe = 1'b0;
    logic       data_strobe = 1'b0;
    logic       tri_mode = 1'b0;
    logic       pwr_down = 1'b0;
    logic       order_rgb = 1'b0;
    logic [2:0] chan_en = 3'b000;
    logic [2:0] chan_sel;
    logic [1:0] chan_tag;

    int errors = 0;
    int checks = 0;
    int exp_idx = 0;
    bit ds_prev = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chan_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .ref_strobe(ref_strobe), .data_strobe(data_strobe),
        .tri_mode(tri_mode), .pwr_down(pwr_down), .order_rgb(order_rgb),
        .chan_en(chan_en), .chan_sel(chan_sel), .chan_tag(chan_tag)
    );

    task automatic check_out(input string req);
        checks++;
        if (chan_tag != 2'(exp_idx) || chan_sel != (3'b001 << exp_idx)) begin
            errors++;
            $display("FAIL %s: tag=%0d sel=%b expected tag=%0d sel=%b",
                     req, chan_tag, chan_sel, exp_idx, 3'b001 << exp_idx);
        end
    endtask

    function automatic int n_ones(input logic [2:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]);
    endfunction

    function automatic string which_req();
        int n = n_ones(chan_en);
        if (pwr_down) return "R9";
        if (tri_mode) return (data_strobe && !ds_prev) ? "R4" : "R3";
        if (n == 1) return order_rgb ? "R5" : "R6";
        if (n == 2) return "R7";
        return "R8";
    endfunction

    task automatic model_step();
        int n = n_ones(chan_en);
        int lo = 0;
        int hi = 0;
        int f;
        int s;
        if (pwr_down) return;
        for (int i = 2; i >= 0; i--) if (chan_en[i]) lo = i;
        for (int i = 0; i < 3; i++) if (chan_en[i]) hi = i;
        if (tri_mode) begin
            if (data_strobe && !ds_prev) exp_idx = order_rgb ? 0 : 2;
            else if (ref_strobe) exp_idx = (exp_idx + (order_rgb ? 1 : 2)) % 3;
        end else if (n == 1) begin
            exp_idx = lo;
        end else if (n == 2) begin
            f = order_rgb ? lo : hi;
            s = order_rgb ? hi : lo;
            if (ref_strobe) exp_idx = (exp_idx == f) ? s : f;
        end else begin
            exp_idx = 0;
        end
        ds_prev = data_strobe;
    endtask

    task automatic next_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        string req;
        // R1: reset state while inputs move
        repeat (3) begin
            @(negedge clk);
            check_out("R1");
            ref_strobe = ~ref_strobe;
            data_strobe = ~data_strobe;
            chan_en = 3'b100;
        end
        @(negedge clk);
        data_strobe = 1'b0;
        ref_strobe = 1'b0;
        rst_n = 1'b1;
        for (int cfg = 0; cfg < 32; cfg++) begin
            tri_mode  = cfg[4];
            order_rgb = cfg[3];
            chan_en   = cfg[2:0];
            for (int c = 0; c < 200; c++) begin
                next_lfsr();
                ref_strobe  = lfsr[0] | lfsr[1];
                data_strobe = (lfsr[4:2] == 3'b000) || (lfsr[4:2] == 3'b111 && ds_prev);
                pwr_down    = (lfsr[7:5] == 3'b000);
                req = which_req();
                model_step();
                @(negedge clk);
                check_out(req);
                checks++; // R2: select/tag consistency
                if (chan_sel != (3'b001 << chan_tag)) begin
                    errors++;
                    $display("FAIL R2: sel=%b expected %b", chan_sel, 3'b001 << chan_tag);
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: expected completion, actual hang");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule